// File: doc/BRIEF.md
# Page Entry Access Checker

This block sits at the end of a page table walk. It receives the leaf entry the walk found, together with the kind of access being attempted (read, write or instruction fetch) and whether the requester runs in user or supervisor mode. It decides whether the access may proceed. A denied access is reported as one of two faults. An entry whose type field does not mark a leaf gives an invalid-entry fault. A leaf whose rights do not cover the access gives a protection fault.

Rights are not held as separate read, write and execute bits. A 3-bit code in the entry selects one of eight fixed pairs of user rights and supervisor rights. Along with the verdict, the block reports whether the page may be cached. It also returns the entry with its referenced flag set, and its modified flag set when the access was a permitted write. When that updated entry differs from the one supplied, the block raises a write-back request. It holds the request until memory acknowledges it, and accepts no new entry while the request is pending.

The controller has three states. `ST_EMPTY` holds no result and is left only through transition *take* (an accepted entry). `ST_HOLD` holds a result that needs no write-back. `ST_WBWAIT` holds a result whose updated entry must be written back. Transition *take* goes from `ST_EMPTY` or `ST_HOLD` to `ST_HOLD` when no write-back is needed, or to `ST_WBWAIT` when one is. Transition *ack* goes from `ST_WBWAIT` to `ST_HOLD` when `wb_ack` is seen. Each state stays where it is when neither transition fires.

Top module: `pec_access_checker`

## Requirements
- R1: When entry bits [1:0] are not 2, the result is an invalid-entry fault (`res_fault` = 1), `res_allow` is 0, `res_entry` equals the input entry and no write-back is requested. This holds whatever the permission code is.
- R2: Entry bits [4:2] hold the rights code. The pairs it selects, written user/supervisor, are: 0 R/R, 1 RW/RW, 2 RX/RX, 3 RWX/RWX, 4 X/X, 5 R/RW, 6 none/RX, 7 none/RWX. The `in_kind` encoding is 0 read, 1 write, 2 execute. An access is allowed exactly when the right for its kind is present for its mode.
- R3: A user-mode access with rights code 6 or 7 is always denied with a protection fault.
- R4: A leaf entry whose rights do not cover the access gives `res_fault` = 2 and `res_allow` = 0. The entry comes back unchanged and no write-back is requested. A permitted access gives `res_fault` = 0.
- R5: `res_nocache` is the inverse of entry bit 7, for every result.
- R6: On a permitted access the updated entry has bit 5 (referenced) set. On a permitted write it also has bit 6 (modified) set. All other bits equal the input.
- R7: `wb_req` rises with the result only when the updated entry differs from the input entry. While `wb_req` is high and `wb_ack` is low, `wb_req` and `res_entry` stay unchanged and `in_ready` is 0.
- R8: An entry accepted on a clock edge (`in_valid` and `in_ready` both high) produces `res_valid` for exactly one cycle, starting at the next edge.
- R9: After reset `res_valid` and `wb_req` are 0 and `in_ready` is 1.
- R10: Access kind 3 is reserved and gives a protection fault on a leaf entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry and access description are present |
| in_ready | output | 1 | Block can take an entry (low while a write-back waits) |
| in_entry | input | ENTRY_W | Leaf entry from the walk |
| in_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| in_super | input | 1 | 1 for supervisor mode, 0 for user mode |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_allow | output | 1 | Access is permitted |
| res_fault | output | 2 | 0 none, 1 invalid entry, 2 protection |
| res_nocache | output | 1 | Access must bypass the cache |
| res_entry | output | ENTRY_W | Entry with referenced/modified flags updated |
| wb_req | output | 1 | Updated entry must be written back |
| wb_ack | input | 1 | Memory has taken the write-back |

## Verification
The case that is hardest to reach from the ports is a write-back that waits for several cycles while the source already has the next entry ready. Only in that case can the stall, the held entry and the blocked input be observed together. To get there, the bench acknowledges every write-back a few cycles late, and it applies the entries for all 8 codes × 2 modes × 4 kinds, with the referenced and modified flags varied, one after another. A stream of permitted accesses on fresh entries therefore keeps hitting a pending request. Entries with both flags already set are also applied, and they must produce a permitted result with no write-back at all.

// File: rtl/pec_pkg.sv
package pec_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PROT    = 2'd2,
        FLT_UNUSED  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_HOLD   = 2'd1,
        ST_WBWAIT = 2'd2
    } state_e;

    // Bit positions the checker decodes inside a leaf entry
    localparam int TYPE_LO   = 0;
    localparam int CODE_LO   = 2;
    localparam int REF_BIT   = 5;
    localparam int MOD_BIT   = 6;
    localparam int CACHE_BIT = 7;
    localparam logic [1:0] TYPE_LEAF = 2'd2;

endpackage

// File: rtl/pec_perm_decode.sv
module pec_perm_decode
    import pec_pkg::*;
#(
    parameter int CODE_W = 3,
    localparam int NCODES = 1 << CODE_W,
    // One bit per rights code: bit n set means code n grants that right
    parameter logic [NCODES-1:0] USR_RD = 8'b0010_1111,
    parameter logic [NCODES-1:0] USR_WR = 8'b0000_1010,
    parameter logic [NCODES-1:0] USR_EX = 8'b0001_1100,
    parameter logic [NCODES-1:0] SUP_RD = 8'b1110_1111,
    parameter logic [NCODES-1:0] SUP_WR = 8'b1010_1010,
    parameter logic [NCODES-1:0] SUP_EX = 8'b1101_1100,
    parameter int USR_MAX_CODE = 5
) (
    input  logic [CODE_W-1:0] code,
    input  acc_kind_e         kind,
    input  logic              super_mode,
    output logic              allow
);

    logic [NCODES-1:0] rd_mask;
    logic [NCODES-1:0] wr_mask;
    logic [NCODES-1:0] ex_mask;
    logic              user_ceiling;

    always_comb begin
        rd_mask = super_mode ? SUP_RD : USR_RD;
        wr_mask = super_mode ? SUP_WR : USR_WR;
        ex_mask = super_mode ? SUP_EX : USR_EX;
        // user accesses above the ceiling code are refused outright
        user_ceiling = !super_mode && (int'(code) > USR_MAX_CODE);
    end

    always_comb begin
        allow = 1'b0;
        unique case (kind)
            ACC_READ:  allow = rd_mask[code];
            ACC_WRITE: allow = wr_mask[code];
            ACC_EXEC:  allow = ex_mask[code];
            ACC_RSVD:  allow = 1'b0;
        endcase
        if (user_ceiling) allow = 1'b0;
    end

endmodule

// File: rtl/pec_entry_update.sv
module pec_entry_update
    import pec_pkg::*;
#(
    parameter int ENTRY_W = 32
) (
    input  logic [ENTRY_W-1:0] entry_in,
    input  logic               permitted,
    input  logic               is_write,
    output logic [ENTRY_W-1:0] entry_out,
    output logic               differs
);

    logic [ENTRY_W-1:0] set_mask;

    always_comb begin
        set_mask = '0;
        set_mask[REF_BIT] = permitted;
        set_mask[MOD_BIT] = permitted && is_write;
        entry_out = entry_in | set_mask;
        differs   = |(entry_out ^ entry_in);
    end

endmodule

// File: rtl/pec_access_checker.sv
module pec_access_checker
    import pec_pkg::*;
#(
    parameter int ENTRY_W = 32,
    parameter int CODE_W  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [ENTRY_W-1:0] in_entry,
    input  logic [1:0]         in_kind,
    input  logic               in_super,
    output logic               res_valid,
    output logic               res_allow,
    output logic [1:0]         res_fault,
    output logic               res_nocache,
    output logic [ENTRY_W-1:0] res_entry,
    output logic               wb_req,
    input  logic               wb_ack
);

    localparam int CODE_HI = CODE_LO + CODE_W - 1;

    state_e             state_q, state_d;
    acc_kind_e          kind_c;
    logic               take;
    logic               leaf_ok;
    logic               rights_ok;
    logic               allow_c;
    fault_e             fault_c;
    logic [ENTRY_W-1:0] upd_entry;
    logic               upd_differs;

    assign kind_c  = acc_kind_e'(in_kind);
    assign leaf_ok = (in_entry[TYPE_LO +: 2] == TYPE_LEAF);

    pec_perm_decode #(.CODE_W(CODE_W)) u_perm (
        .code       (in_entry[CODE_HI:CODE_LO]),
        .kind       (kind_c),
        .super_mode (in_super),
        .allow      (rights_ok)
    );

    always_comb begin
        allow_c = leaf_ok && rights_ok;
        if (!leaf_ok)       fault_c = FLT_INVALID;
        else if (!rights_ok) fault_c = FLT_PROT;
        else                fault_c = FLT_NONE;
    end

    pec_entry_update #(.ENTRY_W(ENTRY_W)) u_upd (
        .entry_in  (in_entry),
        .permitted (allow_c),
        .is_write  (kind_c == ACC_WRITE),
        .entry_out (upd_entry),
        .differs   (upd_differs)
    );

    assign in_ready = (state_q != ST_WBWAIT);
    assign take     = in_valid && in_ready;
    assign wb_req   = (state_q == ST_WBWAIT);

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY, ST_HOLD: if (take) state_d = upd_differs ? ST_WBWAIT : ST_HOLD;
            ST_WBWAIT:         if (wb_ack) state_d = ST_HOLD;
            default:           state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_allow   <= 1'b0;
            res_fault   <= FLT_NONE;
            res_nocache <= 1'b0;
            res_entry   <= '0;
        end else begin
            res_valid <= take;
            if (take) begin
                res_allow   <= allow_c;
                res_fault   <= fault_c;
                res_nocache <= !in_entry[CACHE_BIT];
                res_entry   <= upd_entry;
            end
        end
    end

    // R8: one result pulse, one cycle after acceptance
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> res_valid);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !res_valid);
    // R7: a pending write-back holds its entry and blocks input
    a_r7_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(res_entry));
    a_r7_wb_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !in_ready);
    // R1/R4: faulted results never request a write-back
    a_r4_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_fault != FLT_NONE) |-> !wb_req);
    // R3: user access above the ceiling code is refused
    a_r3_user_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_super && (in_entry[CODE_HI:CODE_LO] > 3'd5)
        |=> !res_allow);
    // R6: a permitted result carries the referenced flag
    a_r6_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_allow |-> res_entry[REF_BIT]);

endmodule

// File: tb/test_pec_access_checker.sv
module test_pec_access_checker;

    localparam int EW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [EW-1:0] in_entry = '0;
    logic [1:0]    in_kind = 2'd0;
    logic          in_super = 1'b0;
    logic          res_valid;
    logic          res_allow;
    logic [1:0]    res_fault;
    logic          res_nocache;
    logic [EW-1:0] res_entry;
    logic          wb_req;
    logic          wb_ack = 1'b0;

    always #2.5 clk = ~clk;

    pec_access_checker #(.ENTRY_W(EW)) i_pec_access_checker (
        .clk, .rst_n, .in_valid, .in_ready, .in_entry, .in_kind, .in_super,
        .res_valid, .res_allow, .res_fault, .res_nocache, .res_entry,
        .wb_req, .wb_ack
    );

    typedef struct {
        logic          allow;
        logic [1:0]    fault;
        logic          nocache;
        logic [EW-1:0] entry;
        logic          wb;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    logic [EW-1:0] held_entry = '0;

    // reference rights table: {read, write, exec} for user and supervisor
    function automatic logic [2:0] rights(input logic [2:0] code, input logic sup);
        case (code)
            3'd0: return 3'b100;
            3'd1: return 3'b110;
            3'd2: return 3'b101;
            3'd3: return 3'b111;
            3'd4: return 3'b001;
            3'd5: return sup ? 3'b110 : 3'b100;
            3'd6: return sup ? 3'b101 : 3'b000;
            default: return sup ? 3'b111 : 3'b000;
        endcase
    endfunction

    function automatic exp_t model(input logic [EW-1:0] e, input logic [1:0] k, input logic sup);
        exp_t x;
        logic [2:0] r;
        logic ok;
        r = rights(e[4:2], sup);
        ok = (k == 2'd0) ? r[2] : (k == 2'd1) ? r[1] : (k == 2'd2) ? r[0] : 1'b0;
        x.nocache = !e[7];
        x.entry = e;
        if (e[1:0] != 2'b10) begin
            x.allow = 0; x.fault = 2'd1; x.tag = "R1";
        end else if (!ok) begin
            x.allow = 0; x.fault = 2'd2;
            x.tag = (k == 2'd3) ? "R10" : (!sup && e[4:2] > 3'd5) ? "R3" : "R4";
        end else begin
            x.allow = 1; x.fault = 2'd0; x.tag = "R2";
            x.entry[5] = 1'b1;
            if (k == 2'd1) x.entry[6] = 1'b1;
        end
        x.wb = (x.entry != e);
        return x;
    endfunction

    task automatic fail_line(input string req, input string what, input logic [EW-1:0] act, input logic [EW-1:0] exp);
        n_fail++;
        $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    // driver: waits for in_ready, applies one entry, checks the R8 pulse
    task automatic apply(input logic [EW-1:0] e, input logic [1:0] k, input logic sup);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_entry = e; in_kind = k; in_super = sup; in_valid = 1'b1;
        exp_q.push_back(model(e, k, sup));
        @(negedge clk);
        in_valid = 1'b0;
        n_vec++;
        if (res_valid !== 1'b1) fail_line("R8", "res_valid after accept", {31'd0, res_valid}, 1);
    endtask

    // monitor: scoreboard comparison on every result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && res_valid) begin
                if (exp_q.size() == 0) begin
                    n_vec++;
                    fail_line("R8", "unexpected result", 1, 0);
                end else begin
                    exp_t x;
                    x = exp_q.pop_front();
                    n_vec++;
                    if (res_allow !== x.allow) fail_line(x.tag, "allow", {31'd0, res_allow}, {31'd0, x.allow});
                    if (res_fault !== x.fault) fail_line(x.tag, "fault", {30'd0, res_fault}, {30'd0, x.fault});
                    if (res_nocache !== x.nocache) fail_line("R5", "nocache", {31'd0, res_nocache}, {31'd0, x.nocache});
                    if (res_entry !== x.entry) fail_line("R6", "entry", res_entry, x.entry);
                    if (wb_req !== x.wb) fail_line("R7", "wb_req", {31'd0, wb_req}, {31'd0, x.wb});
                    held_entry = x.entry;
                end
            end else if (rst_n && wb_req) begin
                // R7: pending write-back keeps its entry and blocks input
                n_vec++;
                if (res_entry !== held_entry) fail_line("R7", "held entry", res_entry, held_entry);
                if (in_ready !== 1'b0) fail_line("R7", "in_ready while pending", {31'd0, in_ready}, 0);
            end
        end
    end

    // memory side: acknowledges each write-back after a delay
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            wb_ack = 1'b0;
            if (rst_n && wb_req) begin
                wait_cnt++;
                if (wait_cnt == 3) begin
                    wb_ack = 1'b1;
                    wait_cnt = 0;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: state held in reset
        n_vec++;
        if (res_valid !== 1'b0 || wb_req !== 1'b0 || in_ready !== 1'b1)
            fail_line("R9", "reset outputs", {29'd0, res_valid, wb_req, in_ready}, 32'd1);
        rst_n = 1'b1;
        // R2 R3 R10: every code, mode and kind, flags and cacheability varied
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 2; s++)
                for (int k = 0; k < 4; k++) begin
                    logic [EW-1:0] e;
                    e = {24'h5A3C00 ^ 24'(c * 4099 + k), 8'h00};
                    e[7] = (c + s) % 2 == 1;
                    e[6:5] = 2'((c + k) % 4);
                    e[4:2] = 3'(c);
                    e[1:0] = 2'b10;
                    apply(e, 2'(k), s[0]);
                end
        // R1: non-leaf type values, including a code that would allow everything
        for (int t = 0; t < 4; t++)
            if (t != 2) apply({24'hC0FFEE, 3'b100, 3'd3, 2'(t)}, 2'd1, 1'b1);
        // R7: flags already set, so no write-back is needed
        apply({24'h000123, 3'b111, 3'd3, 2'b10}, 2'd1, 1'b0);
        apply({24'h000456, 3'b011, 3'd0, 2'b10}, 2'd0, 1'b0);
        // R6: write permitted by supervisor only sets both flags
        apply({24'h0ABCDE, 3'b100, 3'd5, 2'b10}, 2'd1, 1'b1);
        repeat (8) @(negedge clk);
        n_vec++;
        if (exp_q.size() != 0) fail_line("R8", "results missing", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule